// File: doc/BRIEF.md
# Cluster-Aware Fast Inter-Processor Doorbell

This block carries short doorbell signals between CPUs that are grouped into clusters. Each CPU presents a 32-bit request word. A select bit says which of two request registers the word was written to. The near register reaches a core inside the sender's own cluster. The far register names both a cluster and a core. The word also carries a delivery kind:
- immediate, which posts at once;
- deferred, which posts after a countdown that the sender programs beforehand;
- retract, which withdraws a deferred post that has not yet fired;
- quiet, which posts without a wake pulse.

Every CPU owns one pending flag. The flag is the fast interrupt line towards that CPU and also the bit the CPU reads back. The CPU clears the flag by writing a 1 to it. Each CPU also has a wake output. It pulses for one cycle whenever a waking delivery lands. Requests to the same CPU in the same cycle, from any number of senders, fold into that one flag.

The block has one clock. The asynchronous active-low reset passes through a two-stage release synchronizer. Each receiving CPU has its own countdown slot. Each sending CPU has its own countdown register.

Top module: `clu_fast_ipi`

## Requirements
- R1: The request word holds the target core in bits [7:0], the target cluster in bits [23:16] and the delivery kind in bits [29:28]. CPU number equals cluster * CORES_PER_CLUSTER + core.
- R2: A request on the near register (req_glb = 0) targets the sender's own cluster and ignores bits [23:16]. A request on the far register (req_glb = 1) uses bits [23:16] as the cluster.
- R3: Kind 0 (immediate) sets the target's fiq_req. The new value is visible from the clock edge that samples the request. wake_out of the target is high for exactly the following cycle.
- R4: Kind 2 (deferred) loads the target's timer with the sender's countdown value D. It sets fiq_req and pulses wake_out D+1 cycles later than an immediate request would. A new deferred request to an armed target restarts the timer. When several senders defer to one target in the same cycle, the lowest-numbered sender's countdown is used.
- R5: Kind 1 (retract) disarms a pending deferred delivery to that target. This includes a timer that expires in the same cycle. A retract also beats a deferred request to the same target in the same cycle. A retract leaves an already-set fiq_req unchanged.
- R6: A status write with stat_wdata bit 1 clears fiq_req on the next edge. A status write with bit 0 has no effect. A delivery in the same cycle as a clear wins, and the flag stays set.
- R7: Kind 3 (quiet) sets fiq_req with the same timing as an immediate request, and wake_out stays low.
- R8: Requests from several senders to one target in the same cycle give a single pending flag, and one clearing write clears it.
- R9: A request whose core is at or above CORES_PER_CLUSTER, or whose cluster is at or above CLUSTERS, changes no output.
- R10: After reset, fiq_req and wake_out are 0, no timer is armed, and every countdown register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | NCPU | Per-sender request strobe |
| req_glb | input | NCPU | Per-sender register select: 1 far, 0 near |
| req_word | input | NCPU*32 | Per-sender request word, sender s in bits [s*32 +: 32] |
| stat_wr | input | NCPU | Per-CPU status register write strobe |
| stat_wdata | input | NCPU | Per-CPU status write data bit 0 (1 clears) |
| cdn_wr | input | NCPU | Per-CPU countdown register write strobe |
| cdn_wdata | input | NCPU*CNT_W | Per-CPU countdown value, CPU s in bits [s*CNT_W +: CNT_W] |
| fiq_req | output | NCPU | Per-CPU pending flag and fast interrupt line |
| wake_out | output | NCPU | Per-CPU one-cycle wake pulse |

## Verification
The bench builds the block with 2 clusters of 2 cores and a 4-bit countdown. At that size every sender, both register selects and every cluster and core value from 0 to 2 can be swept in full. That includes the first out-of-range value on each field. Countdowns 0 to 3 are checked at every edge up to delivery. The small size also makes it cheap to set up the races between retract and expiry, retract and deferred, and clear and set, together with four senders converging on one target.

// File: rtl/fipi_pkg.sv
package fipi_pkg;
  localparam int WORD_W   = 32;
  localparam int CORE_LSB = 0;
  localparam int CL_LSB   = 16;
  localparam int KIND_LSB = 28;

  typedef enum logic [1:0] {
    K_IMM = 2'd0,
    K_RET = 2'd1,
    K_DEF = 2'd2,
    K_NOW = 2'd3
  } ipi_kind_e;
endpackage

// File: rtl/fipi_decode.sv
module fipi_decode
  import fipi_pkg::*;
#(
  parameter int SENDER = 0,
  parameter int NCL    = 2,
  parameter int CPC    = 2,
  localparam int NCPU  = NCL * CPC
) (
  input  logic              vld,
  input  logic              glb,
  input  logic [WORD_W-1:0] word,
  output logic [NCPU-1:0]   tgt_oh,
  output ipi_kind_e         kind
);
  localparam int OWN_CL = SENDER / CPC;

  logic [7:0] core_f;
  logic [7:0] cl_f;
  int         idx;

  always_comb begin
    core_f = word[CORE_LSB +: 8];
    cl_f   = glb ? word[CL_LSB +: 8] : 8'(OWN_CL);
    kind   = ipi_kind_e'(word[KIND_LSB +: 2]);
    idx    = int'(cl_f) * CPC + int'(core_f);
    tgt_oh = '0;
    if (vld && (int'(core_f) < CPC) && (int'(cl_f) < NCL)) begin
      tgt_oh = NCPU'(1) << idx;
    end
  end
endmodule

// File: rtl/fipi_slot.sv
module fipi_slot #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             imm_hit,
  input  logic             nw_hit,
  input  logic             def_hit,
  input  logic             ret_hit,
  input  logic [CNT_W-1:0] def_load,
  input  logic             clr,
  output logic             pend,
  output logic             wake
);
  logic             pend_q, pend_d;
  logic             wake_q, wake_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             expire;
  logic             fire;

  always_comb begin
    expire  = armed_q && (cnt_q == '0);
    fire    = expire && !ret_hit;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (ret_hit) begin
      armed_d = 1'b0;
    end else if (def_hit) begin
      armed_d = 1'b1;
      cnt_d   = def_load;
      cnt_en  = 1'b1;
    end else if (expire) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      cnt_d   = cnt_q - 1'b1;
      cnt_en  = 1'b1;
    end
    if (imm_hit || nw_hit || fire) pend_d = 1'b1;
    else if (clr)                  pend_d = 1'b0;
    else                           pend_d = pend_q;
    wake_d = imm_hit || fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      wake_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      wake_q  <= wake_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pend = pend_q;
  assign wake = wake_q;

  a_r3_imm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    imm_hit |=> (pend && wake));
  a_r7_quiet_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (nw_hit && !imm_hit && !expire) |=> (pend && !wake));
  a_r5_retract_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    ret_hit |=> !armed_q);
  a_r5_retract_keeps_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_hit && pend && !clr) |=> pend);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !imm_hit && !nw_hit && !expire) |=> !pend);
  a_r4_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(imm_hit || nw_hit || expire));
endmodule

// File: rtl/clu_fast_ipi.sv
module clu_fast_ipi
  import fipi_pkg::*;
#(
  parameter int CLUSTERS          = 2,
  parameter int CORES_PER_CLUSTER = 2,
  parameter int CNT_W             = 4,
  localparam int NCPU             = CLUSTERS * CORES_PER_CLUSTER
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCPU-1:0]        req_vld,
  input  logic [NCPU-1:0]        req_glb,
  input  logic [NCPU*WORD_W-1:0] req_word,
  input  logic [NCPU-1:0]        stat_wr,
  input  logic [NCPU-1:0]        stat_wdata,
  input  logic [NCPU-1:0]        cdn_wr,
  input  logic [NCPU*CNT_W-1:0]  cdn_wdata,
  output logic [NCPU-1:0]        fiq_req,
  output logic [NCPU-1:0]        wake_out
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NCPU-1:0]  oh   [NCPU];
  ipi_kind_e        kd   [NCPU];
  logic [CNT_W-1:0] cdn_q [NCPU];

  genvar gs;
  generate
    for (gs = 0; gs < NCPU; gs++) begin : g_src
      fipi_decode #(
        .SENDER (gs),
        .NCL    (CLUSTERS),
        .CPC    (CORES_PER_CLUSTER)
      ) u_dec (
        .vld    (req_vld[gs]),
        .glb    (req_glb[gs]),
        .word   (req_word[gs*WORD_W +: WORD_W]),
        .tgt_oh (oh[gs]),
        .kind   (kd[gs])
      );

      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n)     cdn_q[gs] <= '0;
        else if (cdn_wr[gs]) cdn_q[gs] <= cdn_wdata[gs*CNT_W +: CNT_W];
      end

      a_r1_single_target: assert property (@(posedge clk) disable iff (!rst_int_n)
        $onehot0(oh[gs]));
      a_r9_core_range: assert property (@(posedge clk) disable iff (!rst_int_n)
        (req_word[gs*WORD_W +: 8] >= 8'(CORES_PER_CLUSTER)) |-> (oh[gs] == '0));
    end
  endgenerate

  logic [NCPU-1:0]  imm_v, nw_v, def_v, ret_v, clr_v;
  logic [CNT_W-1:0] dl [NCPU];

  always_comb begin
    for (int t = 0; t < NCPU; t++) begin
      imm_v[t] = 1'b0;
      nw_v[t]  = 1'b0;
      def_v[t] = 1'b0;
      ret_v[t] = 1'b0;
      dl[t]    = '0;
      for (int s = NCPU - 1; s >= 0; s--) begin
        if (oh[s][t]) begin
          case (kd[s])
            K_IMM: imm_v[t] = 1'b1;
            K_NOW: nw_v[t]  = 1'b1;
            K_RET: ret_v[t] = 1'b1;
            K_DEF: begin
              def_v[t] = 1'b1;
              dl[t]    = cdn_q[s];
            end
            default: ;
          endcase
        end
      end
      clr_v[t] = stat_wr[t] & stat_wdata[t];
    end
  end

  genvar gt;
  generate
    for (gt = 0; gt < NCPU; gt++) begin : g_tgt
      fipi_slot #(.CNT_W(CNT_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .imm_hit  (imm_v[gt]),
        .nw_hit   (nw_v[gt]),
        .def_hit  (def_v[gt]),
        .ret_hit  (ret_v[gt]),
        .def_load (dl[gt]),
        .clr      (clr_v[gt]),
        .pend     (fiq_req[gt]),
        .wake     (wake_out[gt])
      );

      a_r8_merge_one_flag: assert property (@(posedge clk) disable iff (!rst_int_n)
        ($countones({imm_v[gt], nw_v[gt]}) != 0) |=> fiq_req[gt]);
    end
  endgenerate
endmodule

// File: tb/clu_fast_ipi_tb_top.sv
module clu_fast_ipi_tb_top;
  localparam int NCL = 2;
  localparam int CPC = 2;
  localparam int CW  = 4;
  localparam int N   = NCL * CPC;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    req_vld, req_glb, stat_wr, stat_wdata, cdn_wr;
  logic [N*32-1:0] req_word;
  logic [N*CW-1:0] cdn_wdata;
  logic [N-1:0]    fiq_req, wake_out;

  int  n_chk;
  int  n_fail;
  bit  done;

  clu_fast_ipi #(.CLUSTERS(NCL), .CORES_PER_CLUSTER(CPC), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_glb(req_glb),
    .req_word(req_word), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .cdn_wr(cdn_wr), .cdn_wdata(cdn_wdata), .fiq_req(fiq_req), .wake_out(wake_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mk(int core, int cl, int kind);
    return {2'b00, 2'(kind), 4'h0, 8'(cl), 8'h00, 8'(core)};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    req_vld = '0;
    stat_wr = '0;
    cdn_wr  = '0;
  endtask

  task automatic send(int s, bit g, logic [31:0] w);
    req_vld[s]        = 1'b1;
    req_glb[s]        = g;
    req_word[s*32 +: 32] = w;
  endtask

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    stat_wr    = '1;
    stat_wdata = '1;
    step();
    idle();
  endtask

  task automatic set_cdn(int s, int d);
    cdn_wr[s]            = 1'b1;
    cdn_wdata[s*CW +: CW] = CW'(d);
    step();
    idle();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    req_vld = '0; req_glb = '0; req_word = '0; stat_wr = '0;
    stat_wdata = '0; cdn_wr = '0; cdn_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset pend", fiq_req, '0);
    chk("R10 reset wake", wake_out, '0);
    rst_n = 1'b1;
    repeat (4) step();

    // R10: countdown register resets to 0 -> deferred posts one cycle after immediate timing
    send(3, 1'b1, mk(0, 0, 2));
    step(); idle();
    chk("R10 zero countdown edge0", fiq_req, '0);
    step();
    chk("R10 zero countdown edge1", fiq_req, 4'b0001);
    clear_all();

    // R1 R2 R3 R9 sweep
    for (int s = 0; s < N; s++) begin
      for (int g = 0; g < 2; g++) begin
        for (int cl = 0; cl < 3; cl++) begin
          for (int co = 0; co < 3; co++) begin
            int ecl;
            logic [N-1:0] exp;
            ecl = (g == 1) ? cl : s / CPC;
            exp = (ecl < NCL && co < CPC) ? N'(1) << (ecl * CPC + co) : '0;
            send(s, g[0], mk(co, cl, 0));
            step(); idle();
            if (exp == '0) begin
              chk("R9 out of range pend", fiq_req, exp);
            end else if (g == 0) begin
              chk("R2 near register pend", fiq_req, exp);
            end else begin
              chk("R1 far register pend", fiq_req, exp);
            end
            chk("R3 immediate wake", wake_out, exp);
            clear_all();
            chk("R6 clear all", fiq_req, '0);
          end
        end
      end
    end

    // R3: wake lasts one cycle
    send(0, 1'b0, mk(1, 0, 0));
    step(); idle();
    step();
    chk("R3 wake one cycle", wake_out, '0);
    chk("R3 pend holds", fiq_req, 4'b0010);

    // R6: write of 0 has no effect
    stat_wr[1] = 1'b1; stat_wdata[1] = 1'b0;
    step(); idle();
    chk("R6 zero write ignored", fiq_req, 4'b0010);
    clear_all();

    // R6: set wins over same-cycle clear
    send(1, 1'b1, mk(0, 1, 0));
    stat_wr[2] = 1'b1; stat_wdata[2] = 1'b1;
    step(); idle();
    chk("R6 set beats clear", fiq_req, 4'b0100);
    clear_all();

    // R7: quiet delivery
    send(2, 1'b1, mk(0, 0, 3));
    step(); idle();
    chk("R7 quiet pend", fiq_req, 4'b0001);
    chk("R7 quiet no wake", wake_out, '0);
    clear_all();

    // R4: countdown sweep
    for (int d = 0; d < 4; d++) begin
      set_cdn(1, d);
      send(1, 1'b1, mk(0, 1, 2));
      step(); idle();
      chk("R4 deferred edge0", fiq_req, '0);
      for (int k = 1; k <= d + 1; k++) begin
        step();
        chk("R4 deferred pend", fiq_req, (k == d + 1) ? 4'b0100 : 4'b0000);
        chk("R4 deferred wake", wake_out, (k == d + 1) ? 4'b0100 : 4'b0000);
      end
      step();
      chk("R4 deferred wake ends", wake_out, '0);
      clear_all();
    end

    // R4: restart of an armed timer
    set_cdn(1, 3);
    send(1, 1'b1, mk(1, 1, 2));
    step(); idle();
    step();
    send(1, 1'b1, mk(1, 1, 2));
    step(); idle();
    for (int k = 1; k <= 4; k++) begin
      step();
      chk("R4 restart", fiq_req, (k == 4) ? 4'b1000 : 4'b0000);
    end
    clear_all();

    // R4: lowest-numbered sender supplies the countdown
    set_cdn(0, 0);
    set_cdn(2, 3);
    send(0, 1'b1, mk(1, 0, 2));
    send(2, 1'b1, mk(1, 0, 2));
    step(); idle();
    step();
    chk("R4 lowest sender countdown", fiq_req, 4'b0010);
    clear_all();

    // R5: retract in the expiry cycle
    set_cdn(1, 1);
    send(1, 1'b1, mk(1, 1, 2));
    step(); idle();
    step();
    send(0, 1'b1, mk(1, 1, 1));
    step(); idle();
    for (int k = 0; k < 4; k++) begin
      chk("R5 retract at expiry", fiq_req, '0);
      step();
    end

    // R5: retract beats same-cycle deferred
    set_cdn(1, 0);
    send(1, 1'b1, mk(0, 0, 2));
    send(0, 1'b0, mk(0, 0, 1));
    step(); idle();
    for (int k = 0; k < 4; k++) begin
      chk("R5 retract beats deferred", fiq_req, '0);
      step();
    end

    // R5: retract leaves a set flag
    send(3, 1'b0, mk(1, 0, 0));
    step(); idle();
    send(0, 1'b1, mk(1, 1, 1));
    step(); idle();
    chk("R5 retract keeps pend", fiq_req, 4'b1000);
    clear_all();

    // R8: four senders converge on CPU 3
    send(0, 1'b1, mk(1, 1, 0));
    send(1, 1'b1, mk(1, 1, 3));
    send(2, 1'b0, mk(1, 0, 0));
    send(3, 1'b0, mk(1, 0, 3));
    step(); idle();
    chk("R8 merged pend", fiq_req, 4'b1000);
    chk("R8 merged wake", wake_out, 4'b1000);
    stat_wr[3] = 1'b1; stat_wdata[3] = 1'b1;
    step(); idle();
    chk("R8 single clear", fiq_req, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule